// File: doc/BRIEF.md
# Instruction Bus-Cycle Sequencer

This block steps a small 8-bit accumulator processor through its instructions one bus cycle at a time. In every clock cycle it places one address on the bus and marks the access as a read or a write. A flag is raised in the cycle that fetches an opcode. A step index tells the rest of the chip which cycle of the current instruction is running. Four instructions are supported: load accumulator with an immediate byte, copy accumulator to the index register, call subroutine at an absolute address, and increment a byte at an absolute address offset by the index register. Any other opcode is treated as a two-cycle no-op.

A small register set is kept so that results can be observed at the ports. It holds the program counter, accumulator, index, stack pointer, and zero and negative flags. Writes to internal registers do not get a cycle of their own. They are held as pending and committed at the end of the next opcode-fetch cycle, which overlaps the next instruction's first cycle. Stores to memory always get a dedicated final cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, the program counter is RESET_PC (default 0x0200), the stack pointer is RESET_SP (default 0xFD), the accumulator and index are 0, and the cycle is an opcode fetch at RESET_PC.
- R2: sync_o is 1 only in an opcode-fetch cycle, where tstate_o is 0. Within an instruction, tstate_o rises by one each cycle.
- R3: Each cycle drives exactly one access, with rw_o = 1 for a read and 0 for a write. Cycles doing internal work perform a dummy read.
- R4: Opcode 0xA9 takes 2 cycles: fetch, then operand read at PC+1. The accumulator takes the operand only at the end of the next opcode-fetch cycle.
- R5: Opcode 0xAA takes 2 cycles. The second is a dummy read of the next byte and does not advance PC. The index register takes the accumulator value at the end of the next opcode-fetch cycle.
- R6: Opcode 0x20 at address P with stack pointer S takes 6 cycles: fetch P, read target-low at P+1, dummy read 0x0100+S, write high byte of P+2 to 0x0100+S, write low byte of P+2 to 0x0100+S-1, read target-high at P+2. The next fetch is at the target.
- R7: During 0x20 the target-low byte is held in the stack pointer. From the end of the call until the end of the next fetch, the stack pointer reads target-low. After that it reads S-2.
- R8: Opcode 0xFE with base B and index X takes 7 cycles: fetch, base-low, base-high, dummy read at {B high, (B low + X) mod 256}, read at B+X, dummy read at B+X, write of the value plus 1 at B+X.
- R9: A write cycle is never an opcode-fetch cycle.
- R10: The zero and negative flags take the written byte's value (zero test and bit 7) at the end of the 0xFE write cycle.
- R11: Any other opcode takes 2 cycles, the second a dummy read at opcode address + 1. The next fetch is at opcode address + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Read data bus (opcodes and operands) |
| addr_o | output | 16 | Address bus |
| rw_o | output | 1 | 1 = read, 0 = write |
| data_o | output | 8 | Write data (valid when rw_o = 0) |
| sync_o | output | 1 | Opcode-fetch cycle marker |
| tstate_o | output | 3 | Cycle index within the instruction |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| x_o | output | 8 | Index register |
| sp_o | output | 8 | Stack pointer |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |

## Verification
The opcode fetch of one instruction shares its cycle with the register commit of the instruction before it. The bench provokes this by running a load directly followed by a copy to index. The copy's dummy cycle must see the freshly loaded value, so the index must equal the immediate byte. It also runs a call followed by an increment. There the stack pointer must still show the parked target-low byte during the fetch and S-2 one cycle later. Each register is sampled both inside the fetch cycle and in the cycle after it, so a commit that comes one cycle early or late is caught.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int TW = 3;

  localparam logic [DW-1:0] OP_LDI  = 8'hA9;
  localparam logic [DW-1:0] OP_TAX  = 8'hAA;
  localparam logic [DW-1:0] OP_JSR  = 8'h20;
  localparam logic [DW-1:0] OP_INCX = 8'hFE;
  localparam logic [DW-1:0] STACK_PAGE = 8'h01;

  typedef enum logic [2:0] {INS_BAD, INS_LDI, INS_TAX, INS_JSR, INS_INCX} ins_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_ACC, PEND_X, PEND_SP} pend_e;
endpackage

// File: rtl/seq_decode.sv
`timescale 1ns/1ps
module seq_decode
  import seq_pkg::*;
(
  input  logic [DW-1:0] op_i,
  output ins_e          ins_o,
  output logic [TW-1:0] last_o
);
  always_comb begin
    unique case (op_i)
      OP_LDI:  begin ins_o = INS_LDI;  last_o = TW'(1); end
      OP_TAX:  begin ins_o = INS_TAX;  last_o = TW'(1); end
      OP_JSR:  begin ins_o = INS_JSR;  last_o = TW'(5); end
      OP_INCX: begin ins_o = INS_INCX; last_o = TW'(6); end
      default: begin ins_o = INS_BAD;  last_o = TW'(1); end
    endcase
  end
endmodule

// File: rtl/seq_timing.sv
`timescale 1ns/1ps
module seq_timing
  import seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  output logic [TW-1:0] t_o,
  output ins_e          ins_o
);
  logic [TW-1:0] t_q, last_q, dec_last;
  ins_e          ins_q, dec_ins;

  seq_decode u_dec (.op_i(data_i), .ins_o(dec_ins), .last_o(dec_last));

  // the opcode is on data_i during step 0; latch it with its length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q    <= '0;
      last_q <= TW'(1);
      ins_q  <= INS_BAD;
    end else if (t_q == '0) begin
      t_q    <= TW'(1);
      last_q <= dec_last;
      ins_q  <= dec_ins;
    end else if (t_q == last_q) begin
      t_q <= '0;
    end else begin
      t_q <= t_q + TW'(1);
    end
  end

  assign t_o   = t_q;
  assign ins_o = ins_q;

  assert_tstate_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_q != '0) |-> (t_q == $past(t_q) + TW'(1)));
endmodule

// File: rtl/seq_datapath.sv
`timescale 1ns/1ps
module seq_datapath
  import seq_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = 16'h0200,
  parameter logic [DW-1:0] RESET_SP = 8'hFD
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic [TW-1:0] t_i,
  input  ins_e          ins_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic [DW-1:0] data_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] sp_o,
  output logic          flag_z_o,
  output logic          flag_n_o
);
  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q, x_q, sp_q, alu_q, dl_q, adl_q, adh_q, pend_val_q;
  logic          cry_q, z_q, n_q, pc_inc;
  pend_e         pend_q;

  // address / direction / write data per step
  always_comb begin
    addr_o = pc_q;
    rw_o   = 1'b1;
    data_o = '0;
    pc_inc = (t_i == '0);
    if (t_i != '0) begin
      unique case (ins_i)
        INS_LDI: pc_inc = 1'b1;
        INS_JSR: begin
          unique case (t_i)
            TW'(1): pc_inc = 1'b1;
            TW'(2): addr_o = {STACK_PAGE, sp_q};
            TW'(3): begin addr_o = {STACK_PAGE, alu_q}; rw_o = 1'b0; data_o = pc_q[AW-1:DW]; end
            TW'(4): begin addr_o = {STACK_PAGE, alu_q}; rw_o = 1'b0; data_o = pc_q[DW-1:0]; end
            default: ;
          endcase
        end
        INS_INCX: begin
          if (t_i <= TW'(2)) pc_inc = 1'b1;
          else addr_o = {adh_q, adl_q};
          if (t_i == TW'(6)) begin rw_o = 1'b0; data_o = dl_q; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= RESET_PC;
      sp_q       <= RESET_SP;
      acc_q      <= '0;
      x_q        <= '0;
      alu_q      <= '0;
      dl_q       <= '0;
      adl_q      <= '0;
      adh_q      <= '0;
      cry_q      <= 1'b0;
      z_q        <= 1'b0;
      n_q        <= 1'b0;
      pend_q     <= PEND_NONE;
      pend_val_q <= '0;
    end else begin
      if (pc_inc) pc_q <= pc_q + AW'(1);
      if (t_i == '0) begin
        // previous instruction's register result lands during this fetch
        unique case (pend_q)
          PEND_ACC: acc_q <= pend_val_q;
          PEND_X:   x_q   <= pend_val_q;
          PEND_SP:  sp_q  <= pend_val_q;
          default: ;
        endcase
        pend_q <= PEND_NONE;
      end else begin
        unique case (ins_i)
          INS_LDI: begin pend_q <= PEND_ACC; pend_val_q <= data_i; end
          INS_TAX: begin pend_q <= PEND_X;   pend_val_q <= acc_q;  end
          INS_JSR: begin
            unique case (t_i)
              TW'(1): begin dl_q <= data_i; alu_q <= sp_q; end
              TW'(2): sp_q  <= dl_q;            // park target low
              TW'(3), TW'(4): alu_q <= alu_q - DW'(1);
              TW'(5): begin
                pc_q       <= {data_i, sp_q};
                pend_q     <= PEND_SP;
                pend_val_q <= alu_q;
              end
              default: ;
            endcase
          end
          INS_INCX: begin
            unique case (t_i)
              TW'(1): adl_q <= data_i;
              TW'(2): begin adh_q <= data_i; {cry_q, adl_q} <= {1'b0, adl_q} + {1'b0, x_q}; end
              TW'(3): adh_q <= adh_q + {{(DW-1){1'b0}}, cry_q};
              TW'(4): dl_q  <= data_i;
              TW'(5): dl_q  <= dl_q + DW'(1);
              TW'(6): begin z_q <= (dl_q == '0); n_q <= dl_q[DW-1]; end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign x_o      = x_q;
  assign sp_o     = sp_q;
  assign flag_z_o = z_q;
  assign flag_n_o = n_q;

  assert_acc_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_i == '0 && pend_q == PEND_ACC) |=> (acc_q == $past(pend_val_q)));
  assert_stack_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rw_o && ins_i == INS_JSR) |-> (addr_o[AW-1:DW] == STACK_PAGE));
  assert_pcl_from_sp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i == INS_JSR && t_i == TW'(5)) |=> (pc_q[DW-1:0] == $past(sp_q)));
  assert_no_store_on_fetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_o |-> (t_i != '0));
  assert_flags_from_store_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_o && ins_i == INS_INCX |=> (z_q == ($past(data_o) == '0)) && (n_q == $past(data_o[DW-1])));
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
  import seq_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0200,
  parameter logic [7:0]  RESET_SP = 8'hFD
)(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  data_i,
  output logic [15:0] addr_o,
  output logic        rw_o,
  output logic [7:0]  data_o,
  output logic        sync_o,
  output logic [2:0]  tstate_o,
  output logic [15:0] pc_o,
  output logic [7:0]  acc_o,
  output logic [7:0]  x_o,
  output logic [7:0]  sp_o,
  output logic        flag_z_o,
  output logic        flag_n_o
);
  logic [TW-1:0] t;
  ins_e          ins;

  seq_timing u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .t_o(t), .ins_o(ins)
  );

  seq_datapath #(.RESET_PC(RESET_PC), .RESET_SP(RESET_SP)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .t_i(t), .ins_i(ins),
    .addr_o(addr_o), .rw_o(rw_o), .data_o(data_o), .pc_o(pc_o),
    .acc_o(acc_o), .x_o(x_o), .sp_o(sp_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o)
  );

  assign sync_o   = (t == '0);
  assign tstate_o = t;

  assert_sync_is_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> rw_o);
  assert_sync_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);
endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i;
  logic [15:0] addr_o, pc_o;
  logic        rw_o, sync_o, flag_z_o, flag_n_o;
  logic [7:0]  data_o, acc_o, x_o, sp_o;
  logic [2:0]  tstate_o;
  logic [7:0]  mem [0:65535];
  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] exp_acc = 8'h00, exp_x = 8'h00, exp_sp = 8'hFD;

  always #2.5 clk = ~clk;

  bus_cycle_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .addr_o(addr_o), .rw_o(rw_o),
    .data_o(data_o), .sync_o(sync_o), .tstate_o(tstate_o), .pc_o(pc_o), .acc_o(acc_o),
    .x_o(x_o), .sp_o(sp_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o)
  );

  assign data_i = mem[addr_o];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // check the current cycle, capture any store, then advance one cycle
  task automatic cyc(input logic [15:0] a, input logic rw, input logic [2:0] t,
                     input logic [7:0] d, input string req);
    chk(req, "addr", addr_o, a);
    chk(req, "rw", {15'd0, rw_o}, {15'd0, rw});
    chk("R2", "sync", {15'd0, sync_o}, {15'd0, (t == 3'd0)});
    chk("R2", "tstate", {13'd0, tstate_o}, {13'd0, t});
    if (!rw) chk(req, "wdata", {8'd0, data_o}, {8'd0, d});
    if (!rw_o) mem[addr_o] = data_o;
    @(negedge clk);
  endtask

  // runs after the fetch cycle: pending commits from the previous instruction
  task automatic commits();
    chk("R4", "acc after fetch", {8'd0, acc_o}, {8'd0, exp_acc});
    chk("R5", "x after fetch", {8'd0, x_o}, {8'd0, exp_x});
    chk("R7", "sp after fetch", {8'd0, sp_o}, {8'd0, exp_sp});
  endtask

  task automatic run_ldi(input logic [15:0] p, input logic [7:0] imm);
    logic [7:0] old;
    old = exp_acc;
    cyc(p, 1'b1, 3'd0, 8'h00, "R4");
    commits();
    old = exp_acc;
    cyc(p + 16'd1, 1'b1, 3'd1, 8'h00, "R4");
    chk("R4", "acc held during next fetch", {8'd0, acc_o}, {8'd0, old});
    exp_acc = imm;
  endtask

  task automatic run_tax(input logic [15:0] p);
    cyc(p, 1'b1, 3'd0, 8'h00, "R5");
    commits();
    cyc(p + 16'd1, 1'b1, 3'd1, 8'h00, "R3");
    chk("R5", "pc not advanced by dummy", pc_o, p + 16'd1);
    exp_x = exp_acc;
  endtask

  task automatic run_jsr(input logic [15:0] p, input logic [15:0] tgt);
    logic [7:0] s;
    logic [15:0] ret;
    cyc(p, 1'b1, 3'd0, 8'h00, "R6");
    commits();
    s = exp_sp;
    ret = p + 16'd2;
    cyc(p + 16'd1, 1'b1, 3'd1, 8'h00, "R6");
    cyc({8'h01, s}, 1'b1, 3'd2, 8'h00, "R3");
    cyc({8'h01, s}, 1'b0, 3'd3, ret[15:8], "R6");
    cyc({8'h01, s - 8'd1}, 1'b0, 3'd4, ret[7:0], "R6");
    cyc(p + 16'd2, 1'b1, 3'd5, 8'h00, "R6");
    chk("R7", "sp holds target low", {8'd0, sp_o}, {8'd0, tgt[7:0]});
    chk("R6", "pc is target", pc_o, tgt);
    chk("R6", "stack high byte", {8'd0, mem[{8'h01, s}]}, {8'd0, ret[15:8]});
    chk("R6", "stack low byte", {8'd0, mem[{8'h01, s - 8'd1}]}, {8'd0, ret[7:0]});
    exp_sp = s - 8'd2;
  endtask

  task automatic run_inc(input logic [15:0] p, input logic [15:0] base);
    logic [15:0] ea, dummy;
    logic [7:0] res;
    cyc(p, 1'b1, 3'd0, 8'h00, "R8");
    commits();
    ea = base + {8'd0, exp_x};
    dummy = {base[15:8], ea[7:0]};
    res = mem[ea] + 8'd1;
    cyc(p + 16'd1, 1'b1, 3'd1, 8'h00, "R8");
    cyc(p + 16'd2, 1'b1, 3'd2, 8'h00, "R8");
    cyc(dummy, 1'b1, 3'd3, 8'h00, "R8");
    cyc(ea, 1'b1, 3'd4, 8'h00, "R8");
    cyc(ea, 1'b1, 3'd5, 8'h00, "R3");
    chk("R9", "no sync on store", {15'd0, sync_o}, 16'd0);
    cyc(ea, 1'b0, 3'd6, res, "R8");
    chk("R8", "memory result", {8'd0, mem[ea]}, {8'd0, res});
    chk("R10", "zero flag", {15'd0, flag_z_o}, {15'd0, (res == 8'd0)});
    chk("R10", "negative flag", {15'd0, flag_n_o}, {15'd0, res[7]});
  endtask

  task automatic run_bad(input logic [15:0] p);
    cyc(p, 1'b1, 3'd0, 8'h00, "R11");
    commits();
    cyc(p + 16'd1, 1'b1, 3'd1, 8'h00, "R11");
    chk("R11", "next fetch address", pc_o, p + 16'd1);
  endtask

  task automatic load(input logic [15:0] a, input logic [7:0] b);
    mem[a] = b;
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    load(16'h0200, 8'hA9); load(16'h0201, 8'h5A);
    load(16'h0202, 8'hAA);
    load(16'h0203, 8'h20); load(16'h0204, 8'h00); load(16'h0205, 8'h03);
    load(16'h0300, 8'hFE); load(16'h0301, 8'hF0); load(16'h0302, 8'h10);
    load(16'h0303, 8'hA9); load(16'h0304, 8'h80);
    load(16'h0305, 8'hFE); load(16'h0306, 8'h00); load(16'h0307, 8'h20);
    load(16'h0308, 8'h02);
    load(16'h0309, 8'hAA);
    load(16'h030A, 8'hA9); load(16'h030B, 8'h01);
    load(16'h030C, 8'h02);
    load(16'h114A, 8'hFF);
    load(16'h205A, 8'h7F);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pc in reset", pc_o, 16'h0200);
    chk("R1", "sp in reset", {8'd0, sp_o}, 16'h00FD);
    chk("R1", "acc in reset", {8'd0, acc_o}, 16'h0000);
    chk("R1", "x in reset", {8'd0, x_o}, 16'h0000);
    chk("R1", "fetch addr in reset", addr_o, 16'h0200);
    rst_ni = 1'b1;
    run_ldi(16'h0200, 8'h5A);
    run_tax(16'h0202);        // index must see the freshly committed load
    run_jsr(16'h0203, 16'h0300);
    run_inc(16'h0300, 16'h10F0);  // page-crossing index, wraps FF->00
    run_ldi(16'h0303, 8'h80);
    run_inc(16'h0305, 16'h2000);  // no page crossing, 7F->80
    run_bad(16'h0308);
    run_tax(16'h0309);
    run_ldi(16'h030A, 8'h01);
    run_bad(16'h030C);
    chk("R5", "x after second copy", {8'd0, x_o}, 16'h0080);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule